// File: doc/BRIEF.md
# I2C Sign-Magnitude Current DAC Register Slave

This block is the digital front end of a multi-channel current DAC that can either sink or source current. It acts as a bit-level I2C slave. The system clock samples the SCL and SDA lines, so no logic runs on the bus clock. Behind the slave sits a small bank of output-control registers, one per channel. Each register holds a direction bit and a 5-bit magnitude code. For every channel the block presents registered source and sink enables and a magnitude code to the analog stage.

A bus master addresses the slave with its 7-bit device address. The first byte written after the address byte sets an internal register pointer. Each following byte writes the register that the pointer selects, and the pointer then advances by one. To read, the master sets the pointer with a short write, issues a repeated START and reads a burst of bytes. The pointer advances after each byte the master acknowledges. The channel registers sit at consecutive pointer values starting at a parameterised base (F8h by default), in channel order. The default build has four channels, and a two-channel build keeps only the first two addresses.

Top module: `idac_i2c_regs`

## Requirements
- R1: The slave pulls SDA low in the ninth clock of an address byte whose upper seven bits equal DEV_ADDR. Any other address gets no acknowledge, and the bytes that follow it up to the next START write nothing.
- R2: The first byte written after the address selects the register pointer. Each later byte in the same transfer writes the selected register, and the pointer then increments, so a burst fills consecutive channels.
- R3: Register bit 7 selects the direction (1 = source, 0 = sink), and bits 4:0 hold the magnitude code presented on `chan_mag`. Writing 92h gives a sourcing channel with magnitude 12h.
- R4: When the magnitude code is 00000b, both `chan_source` and `chan_sink` of that channel are low, whatever the direction bit holds.
- R5: Bits 6:5 of a channel register are reserved. Values written to them are dropped, and they read back as zero.
- R6: After reset, every channel register is 00h, all direction outputs are low, all magnitudes are zero, and SDA is released.
- R7: Pointer values outside the channel range are acknowledged. Writes to them change no channel, and reads from them return 00h.
- R8: The slave acknowledges every written byte in its ninth clock. It only ever pulls SDA low or releases it, and it releases SDA while receiving data bits.
- R9: After a repeated START with the read bit set, the slave sends the selected register MSB first, with each bit changing after an SCL fall. The pointer advances after each byte the master acknowledges.
- R10: A master NACK after a read byte stops transmission, and SDA stays released until the next START.
- R11: A STOP returns the slave to idle with SDA released. Bits clocked in without a START are neither acknowledged nor stored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | I2C clock line as seen on the bus |
| sda_i | input | 1 | I2C data line as seen on the bus |
| sda_drive_low | output | 1 | 1 = pull SDA low (open-drain enable), 0 = release |
| chan_source | output | NUM_CH | Per channel: sourcing current with a non-zero magnitude |
| chan_sink | output | NUM_CH | Per channel: sinking current with a non-zero magnitude |
| chan_mag | output | NUM_CH*5 | Per channel 5-bit magnitude code, channel 0 in the low bits |

## Verification
The main write path is driven by bursts that start at the first channel address and fill all four channels. Over the sweep, every one of the 256 byte values reaches exactly one channel. This separates the direction bit from the magnitude bits and the reserved bits, and it covers zero magnitude with both signs set. Periodic read-back bursts through a repeated START check the MSB-first serialisation, the pointer advance and reserved-bit masking, independently of the output pins. Further patterns cover a wrong device address, pointers outside the channel range on both sides, a master NACK followed by extra clocks, and bits clocked without a START. These tell apart a slave that decodes addresses, frames and conditions correctly from one that merely counts SCL edges.

// File: rtl/idac_pkg.sv
package idac_pkg;

    localparam int MAG_W  = 5;
    localparam int BYTE_W = 8;

    // one channel control register (reserved bits are not stored)
    typedef struct packed {
        logic             sign;   // 1 = source, 0 = sink
        logic [MAG_W-1:0] mag;
    } chan_reg_t;

    // register write request from the bus engine
    typedef struct packed {
        logic              we;
        logic [BYTE_W-1:0] addr;
        logic [BYTE_W-1:0] data;
    } wr_req_t;

    typedef enum logic [2:0] {
        S_IDLE,
        S_ADDR,
        S_ADDR_ACK,
        S_WRX,
        S_WRX_ACK,
        S_RDTX,
        S_RDTX_ACK,
        S_WAIT
    } slv_state_e;

    function automatic logic [BYTE_W-1:0] reg_to_byte(chan_reg_t r);
        return {r.sign, 2'b00, r.mag};
    endfunction

    function automatic chan_reg_t byte_to_reg(logic [BYTE_W-1:0] b);
        chan_reg_t r;
        r.sign = b[BYTE_W-1];
        r.mag  = b[MAG_W-1:0];
        return r;
    endfunction

endpackage

// File: rtl/idac_line_sync.sv
module idac_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic level,
    output logic rise,
    output logic fall
);
    logic [STAGES-1:0] chain;
    logic              prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '1;
            prev  <= 1'b1;
        end else begin
            chain <= {chain[STAGES-2:0], din};
            prev  <= chain[STAGES-1];
        end
    end

    assign level = chain[STAGES-1];
    assign rise  = chain[STAGES-1] & ~prev;
    assign fall  = ~chain[STAGES-1] & prev;

endmodule

// File: rtl/idac_i2c_engine.sv
module idac_i2c_engine
    import idac_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h2C
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl,
    input  logic              sda,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              sda_rise,
    input  logic              sda_fall,
    input  logic [BYTE_W-1:0] rd_data,
    output logic [BYTE_W-1:0] ptr,
    output wr_req_t           wr,
    output logic              sda_low
);
    slv_state_e        state;
    logic [3:0]        cnt;
    logic [BYTE_W-1:0] shreg;
    logic [BYTE_W-1:0] txb;
    logic              rw;
    logic              ptr_set;
    logic              start_c;
    logic              stop_c;

    assign start_c = scl & sda_fall;
    assign stop_c  = scl & sda_rise;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= S_IDLE;
            cnt     <= '0;
            shreg   <= '0;
            txb     <= '0;
            rw      <= 1'b0;
            ptr_set <= 1'b0;
            ptr     <= '0;
            sda_low <= 1'b0;
            wr      <= '0;
        end else begin
            wr.we <= 1'b0;
            if (start_c) begin
                state   <= S_ADDR;
                cnt     <= '0;
                sda_low <= 1'b0;
                ptr_set <= 1'b0;
            end else if (stop_c) begin
                state   <= S_IDLE;
                sda_low <= 1'b0;
            end else begin
                unique case (state)
                    S_ADDR, S_WRX: begin
                        if (scl_rise) begin
                            shreg <= {shreg[BYTE_W-2:0], sda};
                            cnt   <= cnt + 4'd1;
                        end else if (scl_fall && cnt == 4'd8) begin
                            if (state == S_ADDR) begin
                                if (shreg[7:1] == DEV_ADDR) begin
                                    rw      <= shreg[0];
                                    sda_low <= 1'b1;
                                    state   <= S_ADDR_ACK;
                                end else begin
                                    state <= S_WAIT;
                                end
                            end else begin
                                sda_low <= 1'b1;
                                state   <= S_WRX_ACK;
                                if (!ptr_set) begin
                                    ptr     <= shreg;
                                    ptr_set <= 1'b1;
                                end else begin
                                    wr.we   <= 1'b1;
                                    wr.addr <= ptr;
                                    wr.data <= shreg;
                                    ptr     <= ptr + 8'd1;
                                end
                            end
                        end
                    end
                    S_ADDR_ACK: begin
                        if (scl_fall) begin
                            cnt <= '0;
                            if (rw) begin
                                txb     <= rd_data;
                                sda_low <= ~rd_data[BYTE_W-1];
                                state   <= S_RDTX;
                            end else begin
                                sda_low <= 1'b0;
                                state   <= S_WRX;
                            end
                        end
                    end
                    S_WRX_ACK: begin
                        if (scl_fall) begin
                            sda_low <= 1'b0;
                            cnt     <= '0;
                            state   <= S_WRX;
                        end
                    end
                    S_RDTX: begin
                        if (scl_rise) begin
                            cnt <= cnt + 4'd1;
                        end else if (scl_fall) begin
                            if (cnt == 4'd8) begin
                                sda_low <= 1'b0;
                                state   <= S_RDTX_ACK;
                            end else begin
                                txb     <= {txb[BYTE_W-2:0], 1'b0};
                                sda_low <= ~txb[BYTE_W-2];
                            end
                        end
                    end
                    S_RDTX_ACK: begin
                        if (scl_rise) begin
                            if (sda) state <= S_WAIT;
                            else     ptr   <= ptr + 8'd1;
                        end else if (scl_fall) begin
                            cnt     <= '0;
                            txb     <= rd_data;
                            sda_low <= ~rd_data[BYTE_W-1];
                            state   <= S_RDTX;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // R11: a STOP leaves the slave idle with SDA released
    p_stop_release_r11: assert property (@(posedge clk) disable iff (rst)
        stop_c |=> (state == S_IDLE && !sda_low));

    // R8: SDA is released while data or address bits are being received
    p_rx_released_r8: assert property (@(posedge clk) disable iff (rst)
        (state == S_ADDR || state == S_WRX) |-> !sda_low);

    // R10: after a NACK or a foreign address the line stays released
    p_wait_silent_r10: assert property (@(posedge clk) disable iff (rst)
        (state == S_WAIT) |-> !sda_low);

    // R2: a write strobe is only issued once the pointer has been loaded
    p_write_after_ptr_r2: assert property (@(posedge clk) disable iff (rst)
        wr.we |-> ptr_set);

endmodule

// File: rtl/idac_regbank.sv
module idac_regbank
    import idac_pkg::*;
#(
    parameter int          NUM_CH    = 4,
    parameter logic [7:0]  BASE_ADDR = 8'hF8
) (
    input  logic                    clk,
    input  logic                    rst,
    input  wr_req_t                 wr,
    input  logic [BYTE_W-1:0]       rd_addr,
    output logic [BYTE_W-1:0]       rd_data,
    output logic [NUM_CH-1:0]       chan_source,
    output logic [NUM_CH-1:0]       chan_sink,
    output logic [NUM_CH*MAG_W-1:0] chan_mag
);
    localparam logic [7:0] CH_LIMIT = 8'(NUM_CH);

    chan_reg_t         regs_q [NUM_CH];
    logic [BYTE_W-1:0] woff;
    logic [BYTE_W-1:0] roff;
    logic              whit;
    logic              rhit;

    assign woff = wr.addr - BASE_ADDR;
    assign roff = rd_addr - BASE_ADDR;
    assign whit = (wr.addr >= BASE_ADDR) && (woff < CH_LIMIT);
    assign rhit = (rd_addr >= BASE_ADDR) && (roff < CH_LIMIT);

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        logic active;

        always_ff @(posedge clk) begin
            if (rst) begin
                regs_q[i] <= '0;
            end else if (wr.we && whit && woff == 8'(i)) begin
                regs_q[i] <= byte_to_reg(wr.data);
            end
        end

        assign active                    = |regs_q[i].mag;
        assign chan_source[i]            = active & regs_q[i].sign;
        assign chan_sink[i]              = active & ~regs_q[i].sign;
        assign chan_mag[i*MAG_W +: MAG_W] = regs_q[i].mag;

        // R4: zero magnitude never enables a direction
        p_zero_mag_idle_r4: assert property (@(posedge clk) disable iff (rst)
            (chan_mag[i*MAG_W +: MAG_W] == '0) |-> !(chan_source[i] || chan_sink[i]));

        // R7: a register changes only under a write strobe
        p_hold_no_write_r7: assert property (@(posedge clk) disable iff (rst)
            !wr.we |=> $stable(regs_q[i]));

        // R6: reset clears every channel
        p_reset_clear_r6: assert property (@(posedge clk)
            $past(rst) |-> (regs_q[i] == '0));
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (rhit && roff == 8'(i)) rd_data = reg_to_byte(regs_q[i]);
        end
    end

    // R5: reserved bits never read as one
    p_rsv_zero_r5: assert property (@(posedge clk) disable iff (rst)
        rd_data[6:5] == 2'b00);

endmodule

// File: rtl/idac_i2c_regs.sv
module idac_i2c_regs
    import idac_pkg::*;
#(
    parameter int         NUM_CH    = 4,
    parameter logic [6:0] DEV_ADDR  = 7'h2C,
    parameter logic [7:0] BASE_ADDR = 8'hF8,
    parameter int         SYNC_LEN  = 2
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    scl_i,
    input  logic                    sda_i,
    output logic                    sda_drive_low,
    output logic [NUM_CH-1:0]       chan_source,
    output logic [NUM_CH-1:0]       chan_sink,
    output logic [NUM_CH*MAG_W-1:0] chan_mag
);
    localparam int NLINES = 2;   // index 0 = SCL, 1 = SDA

    logic [NLINES-1:0] line_in;
    logic [NLINES-1:0] line_lvl;
    logic [NLINES-1:0] line_rise;
    logic [NLINES-1:0] line_fall;
    logic [BYTE_W-1:0] ptr;
    logic [BYTE_W-1:0] rd_data;
    wr_req_t           wr;

    assign line_in = {sda_i, scl_i};

    for (genvar g = 0; g < NLINES; g++) begin : g_sync
        idac_line_sync #(.STAGES(SYNC_LEN)) u_sync (
            .clk  (clk),
            .rst  (rst),
            .din  (line_in[g]),
            .level(line_lvl[g]),
            .rise (line_rise[g]),
            .fall (line_fall[g])
        );
    end

    idac_i2c_engine #(.DEV_ADDR(DEV_ADDR)) u_engine (
        .clk     (clk),
        .rst     (rst),
        .scl     (line_lvl[0]),
        .sda     (line_lvl[1]),
        .scl_rise(line_rise[0]),
        .scl_fall(line_fall[0]),
        .sda_rise(line_rise[1]),
        .sda_fall(line_fall[1]),
        .rd_data (rd_data),
        .ptr     (ptr),
        .wr      (wr),
        .sda_low (sda_drive_low)
    );

    idac_regbank #(.NUM_CH(NUM_CH), .BASE_ADDR(BASE_ADDR)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .wr         (wr),
        .rd_addr    (ptr),
        .rd_data    (rd_data),
        .chan_source(chan_source),
        .chan_sink  (chan_sink),
        .chan_mag   (chan_mag)
    );

endmodule

// File: tb/idac_i2c_regs_tb.sv
module idac_i2c_regs_tb;
    localparam int         NCH  = 4;
    localparam logic [6:0] DEV  = 7'h2C;
    localparam int         Q    = 5;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_drive_low;
    logic sda_bus;
    logic [NCH-1:0]   chan_source;
    logic [NCH-1:0]   chan_sink;
    logic [NCH*5-1:0] chan_mag;

    int ncmp = 0;
    int nerr = 0;

    always #10 clk = ~clk;

    assign sda_bus = sda_m & ~sda_drive_low;

    idac_i2c_regs #(.NUM_CH(NCH), .DEV_ADDR(DEV)) u_dut (
        .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_bus),
        .sda_drive_low(sda_drive_low), .chan_source(chan_source),
        .chan_sink(chan_sink), .chan_mag(chan_mag)
    );

    task automatic wq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        ncmp++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); sda_m = 1'b0; wq(); scl_m = 1'b0; wq();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wq(); scl_m = 1'b1; wq(); sda_m = 1'b1; wq(); wq();
    endtask

    task automatic bit_out(input logic b);
        sda_m = b; wq(); scl_m = 1'b1; wq(); wq(); scl_m = 1'b0; wq();
    endtask

    task automatic bit_in(output logic b);
        sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); b = sda_bus; wq(); scl_m = 1'b0; wq();
    endtask

    task automatic send_byte(input logic [7:0] v, output logic ack);
        logic a;
        for (int i = 7; i >= 0; i--) bit_out(v[i]);
        bit_in(a);
        ack = ~a;
    endtask

    task automatic recv_byte(input logic ack, output logic [7:0] v);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            bit_in(b);
            v[i] = b;
        end
        bit_out(~ack);
    endtask

    function automatic logic [7:0] sweep_val(input int k, input int ch);
        return 8'(k * 4 + ch);
    endfunction

    task automatic chk_chan(input string req, input int ch, input logic [7:0] v);
        logic on;
        on = |v[4:0];
        chk(req, 32'(chan_mag[ch*5 +: 5]), 32'(v[4:0]));
        chk(req, 32'(chan_source[ch]), 32'(on & v[7]));
        chk(req, 32'(chan_sink[ch]), 32'(on & ~v[7]));
    endtask

    // set pointer then read n bytes via repeated START; compares with exp array
    task automatic read_burst(input string req, input logic [7:0] p, input int n,
                              input logic [7:0] e0, input logic [7:0] e1,
                              input logic [7:0] e2, input logic [7:0] e3);
        logic ack;
        logic [7:0] got;
        logic [7:0] exp [4];
        exp[0] = e0; exp[1] = e1; exp[2] = e2; exp[3] = e3;
        bus_start();
        send_byte({DEV, 1'b0}, ack);
        send_byte(p, ack);
        bus_start();
        send_byte({DEV, 1'b1}, ack);
        chk({req, " R9 read address ack"}, 32'(ack), 32'd1);
        for (int i = 0; i < n; i++) begin
            recv_byte(i != n - 1, got);
            chk(req, 32'(got), 32'(exp[i]));
        end
        bus_stop();
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog actual=running expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", ncmp, nerr);
        $finish;
    end

    initial begin
        logic ack;
        logic [7:0] got;
        logic [7:0] ve [4];

        repeat (4) @(negedge clk);
        rst = 1'b0;
        repeat (4) @(negedge clk);

        // R6: reset state
        chk("R6 sources", 32'(chan_source), 32'd0);
        chk("R6 sinks", 32'(chan_sink), 32'd0);
        chk("R6 magnitudes", 32'(chan_mag), 32'd0);
        chk("R6 sda released", 32'(sda_drive_low), 32'd0);

        // R3: the 92h example
        bus_start();
        send_byte({DEV, 1'b0}, ack); chk("R1 address ack", 32'(ack), 32'd1);
        send_byte(8'hF8, ack);        chk("R8 pointer ack", 32'(ack), 32'd1);
        send_byte(8'h92, ack);        chk("R8 data ack", 32'(ack), 32'd1);
        bus_stop();
        chk("R3 92h source", 32'(chan_source[0]), 32'd1);
        chk("R3 92h magnitude", 32'(chan_mag[4:0]), 32'h12);

        // R1: foreign address, followed by a would-be write
        bus_start();
        send_byte({DEV ^ 7'h01, 1'b0}, ack); chk("R1 foreign address nack", 32'(ack), 32'd0);
        send_byte(8'hF8, ack);               chk("R1 no ack after foreign", 32'(ack), 32'd0);
        send_byte(8'h05, ack);
        bus_stop();
        chk_chan("R1 channel untouched", 0, 8'h92);

        // R2 R3 R4 R5 R8: sweep, each byte value lands in exactly one channel
        for (int k = 0; k < 64; k++) begin
            bus_start();
            send_byte({DEV, 1'b0}, ack);
            send_byte(8'hF8, ack);
            for (int ch = 0; ch < NCH; ch++) begin
                send_byte(sweep_val(k, ch), ack);
                chk("R8 burst byte ack", 32'(ack), 32'd1);
            end
            bus_stop();
            for (int ch = 0; ch < NCH; ch++) chk_chan("R2 R3 R4 burst output", ch, sweep_val(k, ch));
            if (k % 4 == 3) begin
                for (int ch = 0; ch < NCH; ch++) ve[ch] = sweep_val(k, ch) & 8'h9F;
                read_burst("R9 R5 readback", 8'hF8, 4, ve[0], ve[1], ve[2], ve[3]);
            end
        end
        for (int ch = 0; ch < NCH; ch++) ve[ch] = sweep_val(63, ch);

        // R4: zero magnitude with the sign set
        bus_start();
        send_byte({DEV, 1'b0}, ack);
        send_byte(8'hF9, ack);
        send_byte(8'hE0, ack);
        bus_stop();
        chk("R4 zero magnitude source low", 32'(chan_source[1]), 32'd0);
        chk("R4 zero magnitude sink low", 32'(chan_sink[1]), 32'd0);
        ve[1] = 8'hE0;

        // R7: out-of-range pointers on both sides
        bus_start();
        send_byte({DEV, 1'b0}, ack);
        send_byte(8'hFC, ack);
        send_byte(8'h9F, ack); chk("R7 ack above range", 32'(ack), 32'd1);
        bus_stop();
        bus_start();
        send_byte({DEV, 1'b0}, ack);
        send_byte(8'h10, ack);
        send_byte(8'h81, ack); chk("R7 ack below range", 32'(ack), 32'd1);
        bus_stop();
        for (int ch = 0; ch < NCH; ch++) chk_chan("R7 channels unchanged", ch, ve[ch]);
        read_burst("R7 read across low edge", 8'hF7, 2, 8'h00, ve[0] & 8'h9F, 8'h00, 8'h00);
        read_burst("R7 read above range", 8'hFC, 1, 8'h00, 8'h00, 8'h00, 8'h00);

        // R10: master NACK then more clocks, slave must stay released
        bus_start();
        send_byte({DEV, 1'b0}, ack);
        send_byte(8'hFB, ack);
        bus_start();
        send_byte({DEV, 1'b1}, ack);
        recv_byte(1'b0, got);
        chk("R10 byte before nack", 32'(got), 32'(ve[3] & 8'h9F));
        recv_byte(1'b0, got);
        chk("R10 released after nack", 32'(got), 32'hFF);
        bus_stop();

        // R11: STOP mid transfer, then bits without a START
        bus_start();
        send_byte({DEV, 1'b0}, ack);
        send_byte(8'hFA, ack);
        bus_stop();
        chk("R11 sda released after stop", 32'(sda_drive_low), 32'd0);
        send_byte({DEV, 1'b0}, ack); chk("R11 no ack without start", 32'(ack), 32'd0);
        send_byte(8'h1F, ack);
        bus_stop();
        chk_chan("R11 channel unchanged", 2, ve[2]);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", ncmp, nerr);
        $finish;
    end

endmodule